// File: doc/BRIEF.md
# Threshold-Gated Interrupt Priority Selector

This block picks, for a single interrupt target context, which interrupt source should be offered to that context right now. It looks at every source at once: the source must be raised, must not already be in service, and must be enabled for this context. Among those, only sources whose priority lies strictly above the context's threshold are eligible. The highest priority wins, and on a tie the lowest source number wins. Source number 0 is reserved to mean "nothing to offer".

Source state arrives as 32-bit words, so the vectors are padded up to a whole number of words. Priorities arrive as one packed field per real source. The chosen source number and the request level are registered. The request goes out on one of two lines, machine level or supervisor level, chosen by a per-context mode strap. One copy of the block is placed per context, and all copies may share the same pending, in-service and priority state.

Top module: `irqsel_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `win_id_o` becomes 0 and both request lines become 0, whatever the other inputs are.
- R2: A source is a candidate only when its `pend_i` bit is 1, its `taken_i` bit is 0 and its `en_i` bit is 1 (bit n belongs to source n); any one of these missing excludes it.
- R3: A candidate is eligible only if its priority (unsigned field n of `prio_i`, bits n*PRIO_W upward) is strictly greater than `thresh_i`; a priority equal to the threshold does not win.
- R4: Among eligible sources the one with the largest priority is selected; equal priorities resolve to the smallest source number, across word boundaries too.
- R5: When no source is eligible, `win_id_o` is 0 and both request lines are 0.
- R6: Source 0 is never selected, even when its bits are set and its priority is the maximum.
- R7: Vector bits at positions NUM_SRC and above (the padding of the last 32-bit word) never cause a selection.
- R8: A request line is 1 exactly when `win_id_o` is nonzero; it appears on `irq_mach_o` when `ctx_sup_i` was 0 and on `irq_sup_o` when it was 1, never on both.
- R9: Outputs reflect the inputs sampled at the previous rising clock edge: a change to any input is visible one clock later and not before.
- R10: A source with priority 0 never wins, since the threshold is at least 0 and the comparison is strict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_i | input | VEC_W | Pending bit per source, word padded |
| taken_i | input | VEC_W | In-service bit per source, word padded |
| en_i | input | VEC_W | Enable bit per source for this context, word padded |
| prio_i | input | NUM_SRC*PRIO_W | Packed unsigned priority per source |
| thresh_i | input | PRIO_W | Context threshold |
| ctx_sup_i | input | 1 | Mode strap: 0 machine line, 1 supervisor line |
| win_id_o | output | ID_W | Registered selected source number, 0 for none |
| irq_mach_o | output | 1 | Registered machine-level request |
| irq_sup_o | output | 1 | Registered supervisor-level request |

## Verification
The only state is the output register, so a wrong selection shows on `win_id_o` and on the request line exactly one clock after the inputs that caused it. A fault in the reduction tree shows as the wrong winner among equal or neighbouring priorities, which is why ties across the word boundary, threshold equality, source 0 and the padding bits are driven on purpose. Random patterns over all inputs then compare every cycle's result with a scan model computed in the bench, so a mis-steered mode or a stale register shows within that same single cycle.

// File: rtl/irqsel_pkg.sv
// Package: shared constants, types and sizing helpers for the selector.
// Assumes source vectors are delivered in whole 32-bit words.
package irqsel_pkg;

    localparam int WORD_BITS = 32;

    // Which external request line a context drives.
    typedef enum logic {
        CTX_MACH = 1'b0,
        CTX_SUP  = 1'b1
    } ctx_mode_e;

    // Number of 32-bit words needed to hold n source bits.
    function automatic int words_for(input int n);
        return (n + WORD_BITS - 1) / WORD_BITS;
    endfunction

endpackage

// File: rtl/irqsel_cand.sv
// Module: irqsel_cand
// Forms the per-bit eligibility vector: pending, not in service, enabled,
// a real source (not 0, not padding) and priority strictly above threshold.
// Also presents one priority field per vector bit, zero for padding bits.
// Assumes VEC_W >= NUM_SRC.
module irqsel_cand #(
    parameter int NUM_SRC = 40,
    parameter int PRIO_W  = 3,
    parameter int VEC_W   = 64
) (
    input  logic [VEC_W-1:0]          pend_i,
    input  logic [VEC_W-1:0]          taken_i,
    input  logic [VEC_W-1:0]          en_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thresh_i,
    output logic [VEC_W-1:0]          cand_o,
    output logic [VEC_W*PRIO_W-1:0]   leaf_pri_o
);

    for (genvar b = 0; b < VEC_W; b++) begin : g_bit
        localparam bit REAL_SRC = (b != 0) && (b < NUM_SRC);
        logic [PRIO_W-1:0] pri_b;

        if (b < NUM_SRC) begin : g_real
            // Purpose: pick this source's priority field.
            assign pri_b = prio_i[b*PRIO_W +: PRIO_W];
        end else begin : g_pad
            // Purpose: padding bits carry no priority.
            assign pri_b = '0;
        end

        // Purpose: eligibility of this bit position.
        assign cand_o[b] = REAL_SRC && pend_i[b] && !taken_i[b] && en_i[b]
                           && (pri_b > thresh_i);
        assign leaf_pri_o[b*PRIO_W +: PRIO_W] = pri_b;
    end

endmodule

// File: rtl/irqsel_tree.sv
// Module: irqsel_tree
// Balanced binary reduction over eligible leaves. At every node the upper
// (higher-numbered) child replaces the lower one only when it is valid and
// its priority is strictly larger, so ties settle on the lowest number.
// Assumes 2**ID_W >= VEC_W; leaves past VEC_W are empty.
module irqsel_tree #(
    parameter int VEC_W  = 64,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 6
) (
    input  logic [VEC_W-1:0]        cand_i,
    input  logic [VEC_W*PRIO_W-1:0] leaf_pri_i,
    output logic                    best_vld_o,
    output logic [ID_W-1:0]         best_id_o
);

    localparam int LEAVES = 1 << ID_W;
    localparam int NODES  = 2 * LEAVES;

    // Heap layout: node n has children 2n and 2n+1, leaves at LEAVES+k.
    logic              nv [1:NODES-1];
    logic [PRIO_W-1:0] np [2:NODES-1];
    logic [ID_W-1:0]   ni [1:NODES-1];

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < VEC_W) begin : g_used
            // Purpose: load one eligible leaf.
            assign nv[LEAVES+k] = cand_i[k];
            assign np[LEAVES+k] = leaf_pri_i[k*PRIO_W +: PRIO_W];
        end else begin : g_empty
            // Purpose: leaves beyond the vector never win.
            assign nv[LEAVES+k] = 1'b0;
            assign np[LEAVES+k] = '0;
        end
        assign ni[LEAVES+k] = ID_W'(k);
    end

    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        logic take_hi;
        // Purpose: upper child wins only on strictly higher priority.
        assign take_hi = nv[2*n+1] && (!nv[2*n] || (np[2*n+1] > np[2*n]));
        assign nv[n]   = nv[2*n] || nv[2*n+1];
        assign ni[n]   = take_hi ? ni[2*n+1] : ni[2*n];
        if (n > 1) begin : g_pri
            // Purpose: carry the winning priority upward (root needs none).
            assign np[n] = take_hi ? np[2*n+1] : np[2*n];
        end
    end

    assign best_vld_o = nv[1];
    assign best_id_o  = ni[1];

endmodule

// File: rtl/irqsel_out.sv
// Module: irqsel_out
// Output register stage: holds the selected number and steers the request
// to the machine or supervisor line by the mode strap sampled alongside.
// Assumes a valid selection never carries number 0.
module irqsel_out
    import irqsel_pkg::*;
#(
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            best_vld_i,
    input  logic [ID_W-1:0] best_id_i,
    input  logic            ctx_sup_i,
    output logic [ID_W-1:0] win_id_o,
    output logic            irq_mach_o,
    output logic            irq_sup_o
);

    ctx_mode_e mode;
    assign mode = ctx_mode_e'(ctx_sup_i);

    // Purpose: register the selection and the steered request level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_id_o   <= '0;
            irq_mach_o <= 1'b0;
            irq_sup_o  <= 1'b0;
        end else begin
            win_id_o   <= best_vld_i ? best_id_i : '0;
            irq_mach_o <= best_vld_i && (mode == CTX_MACH);
            irq_sup_o  <= best_vld_i && (mode == CTX_SUP);
        end
    end

endmodule

// File: rtl/irqsel_top.sv
// Module: irqsel_top
// Threshold-gated priority selector for one interrupt context. Combines the
// eligibility stage, the reduction tree and the output register.
// Assumes NUM_SRC >= 2 (source 0 is reserved) and PRIO_W >= 1.
module irqsel_top
    import irqsel_pkg::*;
#(
    parameter  int NUM_SRC = 40,
    parameter  int PRIO_W  = 3,
    localparam int VEC_W   = WORD_BITS * words_for(NUM_SRC),
    localparam int ID_W    = $clog2(VEC_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [VEC_W-1:0]          pend_i,
    input  logic [VEC_W-1:0]          taken_i,
    input  logic [VEC_W-1:0]          en_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thresh_i,
    input  logic                      ctx_sup_i,
    output logic [ID_W-1:0]           win_id_o,
    output logic                      irq_mach_o,
    output logic                      irq_sup_o
);

    logic [VEC_W-1:0]        cand;
    logic [VEC_W*PRIO_W-1:0] leaf_pri;
    logic                    best_vld;
    logic [ID_W-1:0]         best_id;

    irqsel_cand #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .VEC_W   (VEC_W)
    ) cand_i (
        .pend_i     (pend_i),
        .taken_i    (taken_i),
        .en_i       (en_i),
        .prio_i     (prio_i),
        .thresh_i   (thresh_i),
        .cand_o     (cand),
        .leaf_pri_o (leaf_pri)
    );

    irqsel_tree #(
        .VEC_W  (VEC_W),
        .PRIO_W (PRIO_W),
        .ID_W   (ID_W)
    ) tree_i (
        .cand_i     (cand),
        .leaf_pri_i (leaf_pri),
        .best_vld_o (best_vld),
        .best_id_o  (best_id)
    );

    irqsel_out #(
        .ID_W (ID_W)
    ) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .best_vld_i (best_vld),
        .best_id_i  (best_id),
        .ctx_sup_i  (ctx_sup_i),
        .win_id_o   (win_id_o),
        .irq_mach_o (irq_mach_o),
        .irq_sup_o  (irq_sup_o)
    );

endmodule

// File: rtl/irqsel_chk.sv
// Module: irqsel_chk
// Property checker bound to irqsel_top. Keeps a one-cycle copy of the inputs
// and relates the registered outputs to them.
module irqsel_chk
    import irqsel_pkg::*;
#(
    parameter  int NUM_SRC = 40,
    parameter  int PRIO_W  = 3,
    localparam int VEC_W   = WORD_BITS * words_for(NUM_SRC),
    localparam int ID_W    = $clog2(VEC_W)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [VEC_W-1:0]          pend_i,
    input logic [VEC_W-1:0]          taken_i,
    input logic [VEC_W-1:0]          en_i,
    input logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input logic [PRIO_W-1:0]         thresh_i,
    input logic                      ctx_sup_i,
    input logic [ID_W-1:0]           win_id_o,
    input logic                      irq_mach_o,
    input logic                      irq_sup_o
);

    logic [VEC_W-1:0]          pend_d, taken_d, en_d;
    logic [NUM_SRC*PRIO_W-1:0] prio_d;
    logic [PRIO_W-1:0]         thresh_d;
    logic                      sup_d;

    // Purpose: remember the inputs the output register saw.
    always_ff @(posedge clk) begin
        pend_d   <= pend_i;
        taken_d  <= taken_i;
        en_d     <= en_i;
        prio_d   <= prio_i;
        thresh_d <= thresh_i;
        sup_d    <= ctx_sup_i;
    end

    // R8: exactly one line high when and only when a source is selected.
    p_req_tracks_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_mach_o && irq_sup_o) && ((irq_mach_o || irq_sup_o) == (win_id_o != '0)));

    // R8: line follows the mode strap of the previous cycle.
    p_sup_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sup_o |-> sup_d);
    p_mach_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mach_o |-> !sup_d);

    // R6, R7: selected number is a real source.
    p_id_real_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(win_id_o) < NUM_SRC);

    // R2: winner was pending, not in service and enabled one cycle earlier.
    p_winner_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id_o != '0) |-> (pend_d[win_id_o] && !taken_d[win_id_o] && en_d[win_id_o]));

    // R3: winner's priority was strictly above the threshold.
    p_above_thresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id_o != '0) |-> (prio_d[int'(win_id_o)*PRIO_W +: PRIO_W] > thresh_d));

endmodule

bind irqsel_top irqsel_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend_i),
    .taken_i    (taken_i),
    .en_i       (en_i),
    .prio_i     (prio_i),
    .thresh_i   (thresh_i),
    .ctx_sup_i  (ctx_sup_i),
    .win_id_o   (win_id_o),
    .irq_mach_o (irq_mach_o),
    .irq_sup_o  (irq_sup_o)
);

// File: tb/irqsel_top_tb_top.sv
// Bench for irqsel_top: directed corner cases followed by seeded random
// patterns, each checked against a scan model of the requirements.
module irqsel_top_tb_top;

    localparam int NUM_SRC = 40;
    localparam int PRIO_W  = 3;
    localparam int VEC_W   = 64;
    localparam int ID_W    = 6;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [VEC_W-1:0]          pend = '0, taken = '0, en = '0;
    logic [NUM_SRC*PRIO_W-1:0] pr = '0;
    logic [PRIO_W-1:0]         th = '0;
    logic                      md = 1'b0;
    logic [ID_W-1:0]           win_id;
    logic                      irq_m, irq_s;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irqsel_top #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend),
        .taken_i    (taken),
        .en_i       (en),
        .prio_i     (pr),
        .thresh_i   (th),
        .ctx_sup_i  (md),
        .win_id_o   (win_id),
        .irq_mach_o (irq_m),
        .irq_sup_o  (irq_s)
    );

    // Scan model: best starts at threshold, strictly greater replaces.
    function automatic int model_id();
        int best = int'(th);
        int id = 0;
        for (int s = 1; s < NUM_SRC; s++) begin
            int p = int'(pr[s*PRIO_W +: PRIO_W]);
            if (pend[s] && !taken[s] && en[s] && p > best) begin
                best = p;
                id = s;
            end
        end
        return id;
    endfunction

    task automatic compare(input string req, input int exp_id, input bit exp_sup);
        bit exp_m = (exp_id != 0) && !exp_sup;
        bit exp_s = (exp_id != 0) && exp_sup;
        checks++;
        if (int'(win_id) != exp_id || irq_m != exp_m || irq_s != exp_s) begin
            errors++;
            $display("FAIL %s: id=%0d m=%0b s=%0b expected id=%0d m=%0b s=%0b",
                     req, win_id, irq_m, irq_s, exp_id, exp_m, exp_s);
        end
    endtask

    // Inputs are already set at a falling edge; sample after the next one.
    task automatic step_check(input string req);
        int e = model_id();
        bit sup = md;
        @(negedge clk);
        compare(req, e, sup);
    endtask

    task automatic clear_all();
        pend = '0; taken = '0; en = '0; pr = '0; th = '0; md = 1'b0;
    endtask

    task automatic arm(input int s, input int p);
        pend[s] = 1'b1;
        en[s]   = 1'b1;
        pr[s*PRIO_W +: PRIO_W] = PRIO_W'(p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset dominates active inputs.
        arm(5, 7);
        repeat (3) @(negedge clk);
        compare("R1", 0, 1'b0);
        rst_n = 1'b1;
        clear_all();
        step_check("R5");

        // R4: single source selected on machine line.
        arm(5, 4);
        step_check("R4");

        // R9: change is not visible before the next edge.
        clear_all();
        arm(9, 6);
        #1 compare("R9", 5, 1'b0);
        @(negedge clk);
        compare("R9", 9, 1'b0);

        // R2: each missing condition excludes.
        taken[9] = 1'b1; step_check("R2");
        taken[9] = 1'b0; en[9] = 1'b0; step_check("R2");
        en[9] = 1'b1; pend[9] = 1'b0; step_check("R2");

        // R3: threshold equality does not win; one below does.
        clear_all(); arm(7, 3); th = 3; step_check("R3");
        th = 2; step_check("R3");

        // R4: ties to lowest, higher priority beats, across words.
        clear_all(); arm(12, 5); arm(30, 5); step_check("R4");
        pr[30*PRIO_W +: PRIO_W] = 3'd6; step_check("R4");
        clear_all(); arm(35, 7); arm(3, 7); step_check("R4");

        // R6: source 0 ignored.
        clear_all(); arm(0, 7); step_check("R6");
        arm(4, 1); step_check("R6");

        // R7: padding bits ignored, last real source selectable.
        clear_all(); pend[63:40] = '1; en[63:40] = '1; step_check("R7");
        arm(39, 2); step_check("R7");

        // R10: priority 0 never wins.
        clear_all(); arm(11, 0); step_check("R10");

        // R8: supervisor mode steering.
        clear_all(); arm(5, 4); md = 1'b1; step_check("R8");

        // R5: nothing eligible again.
        clear_all(); step_check("R5");

        // R2 R3 R4 R8: seeded random patterns.
        for (int i = 0; i < 400; i++) begin
            pend  = {$urandom, $urandom};
            en    = {$urandom, $urandom};
            taken = {$urandom, $urandom} & {$urandom, $urandom};
            for (int s = 0; s < NUM_SRC; s++)
                pr[s*PRIO_W +: PRIO_W] = PRIO_W'($urandom);
            th = PRIO_W'($urandom);
            md = 1'(($urandom));
            step_check("R4");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule